// File: doc/BRIEF.md
# Multi-Cycle Signed Arithmetic Unit

This block computes the sum, difference, product or quotient of two 32-bit two's-complement operands. The caller presents both operands and an operation code, then raises `start` for one cycle. When the unit is idle it takes the request and stores the operands in its own registers. The caller may change the inputs on the following cycle.

Add and subtract complete on the next cycle. Multiply uses a shift-add loop and divide uses a restoring shift-subtract loop, and each runs for 32 iterations. Every operation ends in the same way: `done` is high for one cycle, and `result` then holds the answer until a later operation completes.

The interface has no back-pressure. `start` only has an effect when the unit is idle. A `start` that arrives while a multiply or divide is running is dropped, so the caller waits for `done` before it issues the next request. A request may be issued in the same cycle that `done` is high.

Top module: `seq_arith_unit`

## Requirements
- R1: While `rst_n` is low at a rising clock edge (synchronous reset), the unit goes idle and sets `done` = 0 and `result` = 0.
- R2: Operation encoding on `op_sel`: 2'b00 add, 2'b01 subtract, 2'b10 multiply, 2'b11 divide. An add is accepted at an edge where the unit is idle and `start` = 1. `done` is then high in the very next cycle, and `result` = a + b modulo 2^32 (so 0x7FFFFFFF + 1 = 0x80000000).
- R3: Subtract has the same one-cycle timing as add, and `result` = a - b modulo 2^32.
- R4: Multiply gives the low 32 bits of the signed product. `done` rises 34 cycles after the accepting edge: the accepting edge counts as 1, and `done` is high after edge 34. For example, -7*3 = -21, 2^28*-2 = -536870912, 2^28*32 = 0 and (2^28+5)*32 = 160.
- R5: Divide has the same timing as multiply. The quotient truncates toward zero and is negative exactly when the operand signs differ. For example, -5/3 = -1, 100/51 = 1 and -153156/-3543 = 43.
- R6: Dividing by zero returns 0xFFFFFFFF with the normal divide latency. The unit is then idle again and accepts the next request.
- R7: `done` is a single-cycle pulse per completed operation. `result` changes only in a cycle where `done` is high, and otherwise holds its value.
- R8: `start` is ignored while a multiply or divide is running. The running operation completes with its own result at its own time, and the dropped request produces no `done` of its own.
- R9: Operands and operation are captured on the accepting edge. Changing `a_in`, `b_in` or `op_sel` afterwards does not alter the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| a_in | input | 32 | First operand (dividend for divide) |
| b_in | input | 32 | Second operand (divisor for divide) |
| op_sel | input | 2 | Operation code, encoding given in R2 |
| start | input | 1 | Request; taken only when the unit is idle |
| result | output | 32 | Result of the last completed operation |
| done | output | 1 | One-cycle completion pulse |

## Verification
The fixed vectors cover sign combinations in both multiply and divide. A positive times a negative checks signed handling in the low product bits. Products whose high bits must be dropped check the 32-bit wrap. Divides with mixed signs tell truncation toward zero apart from floor rounding. A batch of generated operand pairs runs through all four operations against an integer reference that updates every cycle. Separate sequences cover a zero divisor, a `start` raised in the middle of a multiply, and inputs scrambled right after the accepting edge, each checking that the completion timing and result are unchanged.

// File: rtl/arith_pkg.sv
`timescale 1ns/1ps
package arith_pkg;
  localparam int unsigned ARITH_W = 32;

  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_SUB = 2'd1,
    OP_MUL = 2'd2,
    OP_DIV = 2'd3
  } arith_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MUL  = 2'd1,
    ST_DIV  = 2'd2
  } arith_st_e;
endpackage

// File: rtl/arith_addsub.sv
`timescale 1ns/1ps
module arith_addsub #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] y
);
  logic [W-1:0] b_eff;

  // subtract as a + ~b + 1 so a single adder serves both
  assign b_eff = sub ? ~b : b;
  assign y     = a + b_eff + {{(W-1){1'b0}}, sub};
endmodule

// File: rtl/arith_mul_seq.sv
`timescale 1ns/1ps
module arith_mul_seq #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] prod,
  output logic         fin
);
  localparam int unsigned CW = $clog2(W + 1);

  logic [W-1:0]  acc;
  logic [W-1:0]  mcand;
  logic [W-1:0]  mplier;
  logic [CW-1:0] cnt;
  logic          fin_q;

  // low W bits of a two's-complement product equal the unsigned ones,
  // so a plain shift-add modulo 2^W is exact for signed operands
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc    <= '0;
      mcand  <= '0;
      mplier <= '0;
      cnt    <= '0;
      fin_q  <= 1'b0;
    end else begin
      fin_q <= 1'b0;
      if (load) begin
        acc    <= '0;
        mcand  <= a;
        mplier <= b;
        cnt    <= CW'(W);
      end else if (cnt != '0) begin
        if (mplier[0]) acc <= acc + mcand;
        mcand  <= mcand << 1;
        mplier <= mplier >> 1;
        cnt    <= cnt - 1'b1;
        if (cnt == CW'(1)) fin_q <= 1'b1;
      end
    end
  end

  assign prod = acc;
  assign fin  = fin_q;
endmodule

// File: rtl/arith_div_seq.sv
`timescale 1ns/1ps
module arith_div_seq #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] quot,
  output logic         fin
);
  localparam int unsigned CW = $clog2(W + 1);

  logic [W-1:0]  rem;
  logic [W-1:0]  quo;
  logic [W-1:0]  dvs;
  logic          neg_q;
  logic          zero_q;
  logic [CW-1:0] cnt;
  logic          fin_q;

  logic [W-1:0]  a_mag;
  logic [W-1:0]  b_mag;
  logic [W:0]    shifted;
  logic          ge;
  logic [W-1:0]  diff_lo;

  assign a_mag   = a[W-1] ? (~a + 1'b1) : a;
  assign b_mag   = b[W-1] ? (~b + 1'b1) : b;
  assign shifted = {rem, quo[W-1]};
  assign ge      = shifted >= {1'b0, dvs};
  // when ge holds the difference is below dvs and fits W bits
  assign diff_lo = shifted[W-1:0] - dvs;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem    <= '0;
      quo    <= '0;
      dvs    <= '0;
      neg_q  <= 1'b0;
      zero_q <= 1'b0;
      cnt    <= '0;
      fin_q  <= 1'b0;
    end else begin
      fin_q <= 1'b0;
      if (load) begin
        rem    <= '0;
        quo    <= a_mag;
        dvs    <= b_mag;
        neg_q  <= a[W-1] ^ b[W-1];
        zero_q <= (b == '0);
        cnt    <= CW'(W);
      end else if (cnt != '0) begin
        rem <= ge ? diff_lo : shifted[W-1:0];
        quo <= {quo[W-2:0], ge};
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) fin_q <= 1'b1;
      end
    end
  end

  assign quot = zero_q ? '1 : (neg_q ? (~quo + 1'b1) : quo);
  assign fin  = fin_q;
endmodule

// File: rtl/seq_arith_unit.sv
`timescale 1ns/1ps
module seq_arith_unit
  import arith_pkg::*;
#(
  parameter int unsigned W = ARITH_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic [1:0]   op_sel,
  input  logic         start,
  output logic [W-1:0] result,
  output logic         done
);
  arith_st_e  st;
  arith_op_e  op_e;
  logic       accept;
  logic       mul_load;
  logic       div_load;
  logic [W-1:0] as_y;
  logic [W-1:0] mul_prod;
  logic         mul_fin;
  logic [W-1:0] div_quot;
  logic         div_fin;
  logic [W-1:0] res_q;
  logic         done_q;

  assign op_e     = arith_op_e'(op_sel);
  assign accept   = (st == ST_IDLE) && start;
  assign mul_load = accept && (op_e == OP_MUL);
  assign div_load = accept && (op_e == OP_DIV);

  arith_addsub #(.W(W)) u_addsub (
    .a   (a_in),
    .b   (b_in),
    .sub (op_e == OP_SUB),
    .y   (as_y)
  );

  arith_mul_seq #(.W(W)) u_mul (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (mul_load),
    .a     (a_in),
    .b     (b_in),
    .prod  (mul_prod),
    .fin   (mul_fin)
  );

  arith_div_seq #(.W(W)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (div_load),
    .a     (a_in),
    .b     (b_in),
    .quot  (div_quot),
    .fin   (div_fin)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      res_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (start) begin
            unique case (op_e)
              OP_ADD, OP_SUB: begin
                res_q  <= as_y;
                done_q <= 1'b1;
              end
              OP_MUL:  st <= ST_MUL;
              OP_DIV:  st <= ST_DIV;
              default: st <= ST_IDLE;
            endcase
          end
        end
        ST_MUL: begin
          if (mul_fin) begin
            res_q  <= mul_prod;
            done_q <= 1'b1;
            st     <= ST_IDLE;
          end
        end
        ST_DIV: begin
          if (div_fin) begin
            res_q  <= div_quot;
            done_q <= 1'b1;
            st     <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign result = res_q;
  assign done   = done_q;
endmodule

// File: rtl/arith_unit_chk.sv
`timescale 1ns/1ps
module arith_unit_chk
  import arith_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic [1:0]   op_sel,
  input logic [W-1:0] b_in,
  input logic [W-1:0] result,
  input logic         done,
  input arith_st_e    st,
  input logic         mul_fin,
  input logic         div_fin
);
  logic busy;
  logic div_cap;
  logic bz_cap;

  assign busy = (st != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_cap <= 1'b0;
      bz_cap  <= 1'b0;
    end else if (!busy && start) begin
      div_cap <= (op_sel == 2'b11);
      bz_cap  <= (b_in == '0);
    end
  end

  // R2
  fast_op_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && !op_sel[1]) |=> done);

  // R4
  slow_op_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && op_sel[1]) |=> (busy && !done));

  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> done);

  // R8
  busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !mul_fin && !div_fin) |=> !done);

  // R6
  div_zero_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && div_cap && bz_cap) |-> (result == '1));
endmodule

bind seq_arith_unit arith_unit_chk #(.W(W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start   (start),
  .op_sel  (op_sel),
  .b_in    (b_in),
  .result  (result),
  .done    (done),
  .st      (st),
  .mul_fin (mul_fin),
  .div_fin (div_fin)
);

// File: tb/seq_arith_unit_tb_top.sv
`timescale 1ns/1ps
module seq_arith_unit_tb_top;
  localparam int W    = 32;
  localparam int SLOW = W + 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [W-1:0]  a_in;
  logic [W-1:0]  b_in;
  logic [1:0]    op_sel;
  logic          start;
  logic [W-1:0]  result;
  logic          done;

  int    n_chk = 0;
  int    n_err = 0;
  string cur_req = "R1";
  bit    armed = 0;

  always #2 clk = ~clk;

  seq_arith_unit dut_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .a_in   (a_in),
    .b_in   (b_in),
    .op_sel (op_sel),
    .start  (start),
    .result (result),
    .done   (done)
  );

  task automatic check(input string tag, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_calc(input logic [1:0] op,
                                           input logic [31:0] a,
                                           input logic [31:0] b);
    longint sa = longint'($signed(a));
    longint sb = longint'($signed(b));
    longint r;
    case (op)
      2'b00:   r = sa + sb;
      2'b01:   r = sa - sb;
      2'b10:   r = sa * sb;
      default: r = (sb == 0) ? -1 : sa / sb;
    endcase
    return r[31:0];
  endfunction

  // cycle-by-cycle reference model
  logic        m_busy;
  int          m_cnt;
  logic [31:0] m_res;
  logic [31:0] m_pend;
  logic        m_done;

  always @(posedge clk) begin
    armed <= 1'b1;
    if (!rst_n) begin
      m_busy <= 1'b0;
      m_cnt  <= 0;
      m_res  <= '0;
      m_pend <= '0;
      m_done <= 1'b0;
    end else begin
      m_done <= 1'b0;
      if (!m_busy) begin
        if (start) begin
          if (!op_sel[1]) begin
            m_res  <= ref_calc(op_sel, a_in, b_in);
            m_done <= 1'b1;
          end else begin
            m_pend <= ref_calc(op_sel, a_in, b_in);
            m_busy <= 1'b1;
            m_cnt  <= W + 1;
          end
        end
      end else begin
        if (m_cnt == 1) begin
          m_res  <= m_pend;
          m_done <= 1'b1;
          m_busy <= 1'b0;
        end
        m_cnt <= m_cnt - 1;
      end
    end
  end

  always @(negedge clk) begin
    if (armed) begin
      check(cur_req, "model done", done, m_done);
      check(cur_req, "model result", result, m_res);
    end
  end

  task automatic run_op(input logic [1:0] op, input logic [31:0] a,
                        input logic [31:0] b, input logic [31:0] exp,
                        input string tag, input bit scramble);
    int n;
    int lat;
    lat = op[1] ? SLOW : 1;
    @(negedge clk);
    cur_req = tag;
    a_in = a; b_in = b; op_sel = op; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (scramble) begin
      a_in = 32'hDEAD_BEEF; b_in = 32'h0; op_sel = ~op;
    end
    n = 1;
    while (!done && n < 80) begin
      @(negedge clk);
      n++;
    end
    check(tag, "latency", n, lat);
    check(tag, "result", result, exp);
    @(negedge clk);
    check("R7", "done pulse width", done, 0);
    check("R7", "result held", result, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog (all requirements): actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] lfsr;
    rst_n = 1'b0; start = 1'b0; a_in = '0; b_in = '0; op_sel = 2'b00;
    repeat (5) @(negedge clk);
    // R1: reset state
    check("R1", "done in reset", done, 0);
    check("R1", "result in reset", result, 0);
    rst_n = 1'b1;

    // R2 / R3
    run_op(2'b00, 32'd7, 32'd3, 32'd10, "R2", 0);
    run_op(2'b00, 32'h7FFF_FFFF, 32'd1, 32'h8000_0000, "R2", 0);
    run_op(2'b01, 32'd7, 32'd1, 32'd6, "R3", 0);
    run_op(2'b01, 32'd0, 32'd1, 32'hFFFF_FFFF, "R3", 0);

    // R4
    run_op(2'b10, 32'd7, 32'd3, 32'd21, "R4", 0);
    run_op(2'b10, -32'sd7, 32'd3, -32'sd21, "R4", 0);
    run_op(2'b10, 32'h1000_0000, -32'sd2, -32'sd536870912, "R4", 0);
    run_op(2'b10, 32'h1000_0000, 32'd32, 32'd0, "R4", 0);
    run_op(2'b10, 32'h1000_0005, 32'd32, 32'd160, "R4", 0);

    // R5
    run_op(2'b11, -32'sd5, 32'd3, -32'sd1, "R5", 0);
    run_op(2'b11, 32'd7, 32'd3, 32'd2, "R5", 0);
    run_op(2'b11, 32'd100, 32'd51, 32'd1, "R5", 0);
    run_op(2'b11, 32'd100, 32'd49, 32'd2, "R5", 0);
    run_op(2'b11, 32'd153156, 32'd3543, 32'd43, "R5", 0);
    run_op(2'b11, -32'sd153156, 32'd3543, -32'sd43, "R5", 0);
    run_op(2'b11, 32'd153156, -32'sd3543, -32'sd43, "R5", 0);
    run_op(2'b11, -32'sd153156, -32'sd3543, 32'd43, "R5", 0);

    // R6: zero divisor, then the unit is usable again
    run_op(2'b11, 32'd17, 32'd0, 32'hFFFF_FFFF, "R6", 0);
    run_op(2'b11, -32'sd17, 32'd0, 32'hFFFF_FFFF, "R6", 0);
    run_op(2'b00, 32'd2, 32'd2, 32'd4, "R6", 0);

    // R9: inputs scrambled right after the accepting edge
    run_op(2'b10, 32'd1234, -32'sd5, -32'sd6170, "R9", 1);
    run_op(2'b11, 32'd1000, 32'd7, 32'd142, "R9", 1);
    run_op(2'b00, 32'd40, 32'd2, 32'd42, "R9", 1);

    // R8: start during a multiply is dropped
    begin
      int n;
      @(negedge clk);
      cur_req = "R8";
      a_in = 32'd5; b_in = 32'd6; op_sel = 2'b10; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      n = 1;
      repeat (4) begin @(negedge clk); n++; end
      a_in = 32'd1; b_in = 32'd1; op_sel = 2'b00; start = 1'b1;
      @(negedge clk);
      n++;
      start = 1'b0;
      check("R8", "no done after dropped start", done, 0);
      while (!done && n < 80) begin @(negedge clk); n++; end
      check("R8", "latency", n, SLOW);
      check("R8", "result", result, 32'd30);
      @(negedge clk);
      check("R8", "no extra done", done, 0);
      check("R8", "result kept", result, 32'd30);
    end

    // generated pairs across all operations
    lfsr = 32'h1ACE_B00C;
    for (int i = 0; i < 24; i++) begin
      logic [31:0] ga;
      logic [31:0] gb;
      logic [1:0]  gop;
      lfsr = lfsr * 32'd1664525 + 32'd1013904223;
      ga = lfsr;
      lfsr = lfsr * 32'd1664525 + 32'd1013904223;
      gb = (i % 3 == 0) ? {{16{lfsr[31]}}, lfsr[15:0]} : lfsr;
      gop = 2'(i % 4);
      run_op(gop, ga, gb, ref_calc(gop, ga, gb),
             (gop == 2'b00) ? "R2" : (gop == 2'b01) ? "R3" :
             (gop == 2'b10) ? "R4" : "R5", 0);
    end

    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule